// File: doc/BRIEF.md
# Synchronous FIFO with Retransmit

This block is a single-clock first-in first-out buffer of parameterizable depth and width. Words are accepted on a write enable and returned in arrival order on a read enable. The read output is registered, and the full and empty flags come directly from the distance between a write pointer and a read pointer. Each pointer carries one bit more than the storage address.

An active-low retransmit input moves the read pointer back to storage location zero and leaves the write pointer alone. A packet that has already been drained can then be read again from its first word. Words written after the rewind follow the replayed ones. While retransmit is low, and for a parameterized number of clocks after it returns high, both enables are ignored. The flags are recomputed in the same edge that rewinds the pointer.

Retransmit gives a correct replay only when the number of writes since reset is no larger than the depth. It is also only meaningful after at least one word has been read. Within that rule the whole depth can be replayed any number of times.

Top module: `fifo_rt`

## Requirements
- R1: While `rst_n` is low and after it is released, `empty` is 1, `full` is 0 and `rd_data` is 0.
- R2: An accepted read returns the oldest stored word on `rd_data` after the clock edge that accepts it. `rd_data` keeps its value in every cycle without an accepted read.
- R3: `full` is 1 exactly when DEPTH words are stored. A write presented while `full` is 1 is dropped and its data never appears on `rd_data`.
- R4: `empty` is 1 exactly when no word is stored. A read presented while `empty` is 1 leaves `rd_data` unchanged.
- R5: A clock edge that samples `rt_n` low sets the read position to storage location zero. From the following cycle, the stored count equals the writes since reset, `full` and `empty` reflect that count, and reads return words from the first one written.
- R6: Writes and reads are ignored at every edge where `rt_n` is low and at the RT_RECOVER edges that follow the last such edge.
- R7: Words written after a retransmit are read out after all the replayed words, in their order of writing.
- R8: A FIFO filled to DEPTH words and fully drained can be retransmitted and read in full, repeatedly, with `full` set right after each rewind.
- R9: A simultaneous read and write outside the recovery window are both accepted when the FIFO is neither empty nor full. The count is then unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write request |
| wr_data | input | WIDTH | Word to store |
| rd_en | input | 1 | Read request |
| rd_data | output | WIDTH | Registered word from the last accepted read |
| rt_n | input | 1 | Active-low retransmit (rewinds the read position) |
| full | output | 1 | DEPTH words stored |
| empty | output | 1 | No word stored |

## Verification
Several input patterns are applied:
- Plain fill-and-drain sequences show ordering and the two flag boundaries. Pushing past full and reading past empty shows that overflow and underflow are dropped, not wrapped.
- A partial packet replayed after a single-cycle retransmit pulse shows the rewind to location zero. A held pulse with both enables asserted through the recovery window shows that no word slips in or out early.
- Writes issued after the rewind, repeated full-depth replays, and a long pseudo-random stretch of mixed simultaneous reads and writes separate correct pointer wraparound from mere ordering.

// File: rtl/fifo_rt.sv
module fifo_rt #(
  parameter int WIDTH      = 16,
  parameter int DEPTH      = 8,
  parameter int RT_RECOVER = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  input  logic             rt_n,
  output logic             full,
  output logic             empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(RT_RECOVER + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW:0]      wptr, rptr;
  logic [CW-1:0]    hold_cnt;
  logic             quiet, wr_go, rd_go;

  assign quiet = !rt_n || (hold_cnt != '0);
  assign empty = (wptr == rptr);
  assign full  = (wptr[AW] != rptr[AW]) && (wptr[AW-1:0] == rptr[AW-1:0]);
  assign wr_go = wr_en && !full  && !quiet;
  assign rd_go = rd_en && !empty && !quiet;

  always_ff @(posedge clk) begin
    if (wr_go) mem[wptr[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr     <= '0;
      rptr     <= '0;
      hold_cnt <= '0;
      rd_data  <= '0;
    end else begin
      if (wr_go) wptr <= wptr + 1'b1;
      if (!rt_n) begin
        rptr     <= '0;
        hold_cnt <= CW'(RT_RECOVER);
      end else begin
        if (hold_cnt != '0) hold_cnt <= hold_cnt - 1'b1;
        if (rd_go) begin
          rd_data <= mem[rptr[AW-1:0]];
          rptr    <= rptr + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/fifo_rt_checker.sv
module fifo_rt_checker #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     wr_en,
  input logic                     rd_en,
  input logic                     rt_n,
  input logic                     full,
  input logic                     empty,
  input logic [WIDTH-1:0]         rd_data,
  input logic [$clog2(DEPTH):0]   rptr
);
  assert_flags_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !rd_en && rt_n) |=> full);

  assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && rd_en) |=> $stable(rd_data));

  assert_empty_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !wr_en && rt_n) |=> empty);

  assert_data_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));

  assert_rewind_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !rt_n |=> (rptr == '0));

  assert_quiet_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !rt_n |=> $stable(rd_data));
endmodule

bind fifo_rt fifo_rt_checker #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_fifo_rt_checker (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .rt_n(rt_n),
  .full(full), .empty(empty), .rd_data(rd_data), .rptr(rptr)
);

// File: tb/fifo_rt_bench.sv
`timescale 1ns/1ps
module fifo_rt_bench;
  localparam int W = 16;
  localparam int D = 8;
  localparam int N = 3;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0, rd_en = 1'b0, rt_n = 1'b1;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] rd_data;
  logic         full, empty;

  always #2 clk = ~clk;

  fifo_rt #(.WIDTH(W), .DEPTH(D), .RT_RECOVER(N)) u_fifo_rt (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .rt_n(rt_n), .full(full), .empty(empty)
  );

  int           checks = 0, failures = 0;
  string        tag = "R1";
  bit           done = 1'b0;
  logic [W-1:0] hist[$];
  int           ridx = 0, cnt = 0;
  logic [W-1:0] exp_data = '0;
  int unsigned  lcg = 32'h1234_5678;

  task automatic chk(string what, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    int occ;
    occ = hist.size() - ridx;
    chk("full",    W'(full),  W'(occ == D));
    chk("empty",   W'(empty), W'(occ == 0));
    chk("rd_data", rd_data,   exp_data);
  endtask

  task automatic cyc(input logic w, input logic r, input logic rtl, input logic [W-1:0] d);
    int occ;
    bit quiet;
    wr_en = w; rd_en = r; rt_n = rtl; wr_data = d;
    @(posedge clk);
    occ   = hist.size() - ridx;
    quiet = !rtl || (cnt != 0);
    if (r && occ > 0 && !quiet) begin
      exp_data = hist[ridx];
      ridx++;
    end
    if (w && occ < D && !quiet) hist.push_back(d);
    if (!rtl) begin
      ridx = 0;
      cnt  = N;
    end else if (cnt > 0) begin
      cnt--;
    end
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 1'b1, '0);
  endtask

  task automatic do_reset();
    wr_en = 0; rd_en = 0; rt_n = 1; rst_n = 0;
    hist.delete(); ridx = 0; cnt = 0; exp_data = '0;
    repeat (2) @(negedge clk);
    tag = "R1";
    compare_all();
    rst_n = 1;
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      failures++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();

    tag = "R2";
    for (int i = 0; i < 5; i++) cyc(1, 0, 1, W'(16'h1100 + i));
    for (int i = 0; i < 5; i++) begin cyc(0, 1, 1, '0); cyc(0, 0, 1, '0); end

    tag = "R3";
    for (int i = 0; i < D; i++) cyc(1, 0, 1, W'(16'h2200 + i));
    for (int i = 0; i < 3; i++) cyc(1, 0, 1, 16'hBAD0);
    tag = "R4";
    for (int i = 0; i < D; i++) cyc(0, 1, 1, '0);
    for (int i = 0; i < 3; i++) cyc(0, 1, 1, '0);

    do_reset();
    tag = "R5";
    for (int i = 0; i < 6; i++) cyc(1, 0, 1, W'(16'h3300 + i));
    for (int i = 0; i < 3; i++) cyc(0, 1, 1, '0);
    cyc(0, 0, 0, '0);
    idle(N);
    for (int i = 0; i < 6; i++) cyc(0, 1, 1, '0);

    do_reset();
    tag = "R6";
    for (int i = 0; i < 4; i++) cyc(1, 0, 1, W'(16'h4400 + i));
    cyc(0, 1, 1, '0);
    cyc(1, 1, 0, 16'hDEAD);
    cyc(1, 1, 0, 16'hDEAD);
    for (int i = 0; i < N; i++) cyc(1, 1, 1, 16'hBEEF);
    cyc(0, 1, 1, '0);
    cyc(0, 1, 1, '0);

    tag = "R7";
    cyc(0, 0, 0, '0);
    idle(N);
    cyc(1, 0, 1, 16'h7701);
    cyc(1, 0, 1, 16'h7702);
    for (int i = 0; i < 7; i++) cyc(0, 1, 1, '0);

    do_reset();
    tag = "R8";
    for (int i = 0; i < D; i++) cyc(1, 0, 1, W'(16'h8800 + i * 3));
    for (int i = 0; i < D; i++) cyc(0, 1, 1, '0);
    for (int k = 0; k < 3; k++) begin
      cyc(0, 0, 0, '0);
      idle(N);
      for (int i = 0; i < D + 1; i++) cyc(0, 1, 1, '0);
    end

    do_reset();
    tag = "R9";
    for (int i = 0; i < 3; i++) cyc(1, 0, 1, W'(16'h9900 + i));
    for (int i = 0; i < 300; i++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      cyc(lcg[20], lcg[25], 1'b1, lcg[15:0]);
    end
    for (int i = 0; i < D + 1; i++) cyc(0, 1, 1, '0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule